// File: doc/BRIEF.md
# Packet Number Replay Checker

This block guards one receive queue against replayed frames. Each frame arrives as a single-cycle strobe with a 128-bit packet number (PN). The block keeps the PN of the last accepted frame, a flag saying whether that stored value is meaningful, and a sticky error flag. Each frame gets one verdict: pass, fail or bypass. A frame passes when its PN is strictly greater than the stored one over the selected width and it meets any parity rule. A passing frame becomes the new reference.

Configuration inputs enable the check, pick a 24-, 48- or 128-bit comparison width, add an even-only or odd-only rule, and choose whether a failure latches the error flag. Software can preload a reference PN, which also marks it as meaningful. If it does not, the first frame checked seeds the reference. Once the error flag is set, every frame is passed straight on for firmware handling as a bypass until software clears the flag.

Top module: `pn_replay_guard`

## Requirements
- R1: A verdict appears as a one-cycle pulse on exactly one of `resPass`, `resFail`, `resBypass`, in the cycle after `frameValid` is sampled high. No verdict pulse appears in any other cycle.
- R2: While `cfgCheckEn` is 0 and `errFlag` is 0, every frame passes, and neither the stored PN nor its valid state changes.
- R3: `cfgWidthSel` picks the compared width: 0 = low 24 bits, 1 = low 48 bits, 2 = all 128 bits. The illegal value 3 behaves as 2. The comparison is unsigned and strict: received > stored, on the low bits only.
- R4: With `cfgEvenOnly` set, a frame whose PN has bit 0 = 1 fails. With `cfgOddOnly` set, a frame whose PN has bit 0 = 0 fails. Both rules apply on top of the ordering check.
- R5: When no reference is held, the first checked frame passes whatever its value, and its PN becomes the reference.
- R6: A `swPreload` pulse stores `swPreloadPn` as the reference and marks it valid. The next frame is then compared against it and is not captured.
- R7: A passing checked frame stores its full PN as the reference. A failing frame leaves the reference unchanged.
- R8: A failing frame sets `errFlag` in the same cycle as the fail pulse, but only if `cfgHandleEn` was 1 when the frame was sampled.
- R9: While `errFlag` is 1, every frame gets a bypass pulse, whatever the configuration. The frame is not checked and the reference is not touched.
- R10: `errFlag` stays set until a `swClearErr` pulse clears it. If a clear and an error set fall in the same cycle, the clear wins.
- R11: After reset no reference is held, `errFlag` is 0 and no verdict pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgCheckEn | input | 1 | Enables the replay check |
| cfgWidthSel | input | 2 | Compared width: 0=24, 1=48, 2/3=128 bits |
| cfgEvenOnly | input | 1 | Require an even PN |
| cfgOddOnly | input | 1 | Require an odd PN |
| cfgHandleEn | input | 1 | A failure latches the error flag |
| frameValid | input | 1 | Frame strobe, one cycle per frame |
| framePn | input | 128 | PN of the arriving frame |
| swPreload | input | 1 | Load `swPreloadPn` as the reference |
| swPreloadPn | input | 128 | Software reference value |
| swClearErr | input | 1 | Clears the sticky error flag |
| resPass | output | 1 | Verdict: frame accepted |
| resFail | output | 1 | Verdict: frame rejected |
| resBypass | output | 1 | Verdict: frame sent on unchecked |
| errFlag | output | 1 | Sticky error flag |

## Verification
The properties assume that `swPreload` never coincides with a frame strobe, and that configuration inputs are steady in the cycle a frame is sampled. The stimulus changes configuration and issues preloads only in cycles with no frame, and drives every input at the falling edge. The one overlap exercised on purpose is a clear arriving together with a failing frame, which the block defines (R10). The illegal width code is driven once, to check it behaves as the 128-bit setting.

// File: rtl/pnr_pkg.sv
package pnr_pkg;
  parameter int PN_BITS  = 128;
  parameter int PN_SHORT = 24;
  parameter int PN_MID   = 48;

  typedef logic [PN_BITS-1:0] pn_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic storeRx;   // take received PN as reference
  } dpStrobe_t;

  function automatic pn_t widthMask(input logic [1:0] sel);
    pn_t m;
    case (sel)
      2'd0:    m = {{(PN_BITS-PN_SHORT){1'b0}}, {PN_SHORT{1'b1}}};
      2'd1:    m = {{(PN_BITS-PN_MID){1'b0}}, {PN_MID{1'b1}}};
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pnr_datapath.sv
module pnr_datapath
  import pnr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  pn_t       framePn,
  input  logic [1:0] widthSel,
  input  logic      swPreload,
  input  pn_t       swPreloadPn,
  input  dpStrobe_t strobe,
  output logic      refValid,
  output logic      rxNewer,
  output logic      rxOdd
);
  pn_t refPn;
  pn_t mask;

  assign mask    = widthMask(widthSel);
  assign rxNewer = (framePn & mask) > (refPn & mask);
  assign rxOdd   = framePn[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPn    <= '0;
      refValid <= 1'b0;
    end else if (swPreload) begin
      refPn    <= swPreloadPn;
      refValid <= 1'b1;
    end else if (strobe.storeRx) begin
      refPn    <= framePn;
      refValid <= 1'b1;
    end
  end
endmodule

// File: rtl/pnr_ctrl.sv
module pnr_ctrl
  import pnr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameValid,
  input  logic      cfgCheckEn,
  input  logic      cfgEvenOnly,
  input  logic      cfgOddOnly,
  input  logic      cfgHandleEn,
  input  logic      swClearErr,
  input  logic      refValid,
  input  logic      rxNewer,
  input  logic      rxOdd,
  output dpStrobe_t strobe,
  output logic      resPass,
  output logic      resFail,
  output logic      resBypass,
  output logic      errFlag
);
  logic passNext, failNext, bypassNext, setErr, parityOk, checked;

  always_comb begin
    parityOk   = !(cfgEvenOnly && rxOdd) && !(cfgOddOnly && !rxOdd);
    checked    = frameValid && !errFlag && cfgCheckEn;
    bypassNext = frameValid && errFlag;
    passNext   = 1'b0;
    failNext   = 1'b0;
    strobe     = '0;
    if (frameValid && !errFlag && !cfgCheckEn) begin
      passNext = 1'b1;
    end else if (checked && !refValid) begin
      passNext       = 1'b1;
      strobe.storeRx = 1'b1;
    end else if (checked) begin
      if (rxNewer && parityOk) begin
        passNext       = 1'b1;
        strobe.storeRx = 1'b1;
      end else begin
        failNext = 1'b1;
      end
    end
    setErr = failNext && cfgHandleEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resPass   <= 1'b0;
      resFail   <= 1'b0;
      resBypass <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      resPass   <= passNext;
      resFail   <= failNext;
      resBypass <= bypassNext;
      if (swClearErr)  errFlag <= 1'b0;
      else if (setErr) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/pn_replay_guard.sv
module pn_replay_guard
  import pnr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgCheckEn,
  input  logic [1:0]   cfgWidthSel,
  input  logic         cfgEvenOnly,
  input  logic         cfgOddOnly,
  input  logic         cfgHandleEn,
  input  logic         frameValid,
  input  logic [127:0] framePn,
  input  logic         swPreload,
  input  logic [127:0] swPreloadPn,
  input  logic         swClearErr,
  output logic         resPass,
  output logic         resFail,
  output logic         resBypass,
  output logic         errFlag
);
  dpStrobe_t strobe;
  logic refValid, rxNewer, rxOdd;

  pnr_datapath u_dp (
    .clk(clk), .rstN(rstN), .framePn(framePn), .widthSel(cfgWidthSel),
    .swPreload(swPreload), .swPreloadPn(swPreloadPn), .strobe(strobe),
    .refValid(refValid), .rxNewer(rxNewer), .rxOdd(rxOdd)
  );

  pnr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .cfgCheckEn(cfgCheckEn),
    .cfgEvenOnly(cfgEvenOnly), .cfgOddOnly(cfgOddOnly), .cfgHandleEn(cfgHandleEn),
    .swClearErr(swClearErr), .refValid(refValid), .rxNewer(rxNewer), .rxOdd(rxOdd),
    .strobe(strobe), .resPass(resPass), .resFail(resFail), .resBypass(resBypass),
    .errFlag(errFlag)
  );
endmodule

// File: rtl/pn_replay_guard_sva.sv
module pn_replay_guard_sva (
  input logic clk,
  input logic rstN,
  input logic cfgCheckEn,
  input logic cfgHandleEn,
  input logic frameValid,
  input logic swClearErr,
  input logic resPass,
  input logic resFail,
  input logic resBypass,
  input logic errFlag
);
  // R1
  assert_one_verdict_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resPass, resFail, resBypass}));
  // R1
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> !(resPass || resFail || resBypass));
  // R2
  assert_disabled_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameValid && !errFlag && !cfgCheckEn |=> resPass);
  // R8
  assert_err_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    !errFlag ##1 errFlag |-> resFail && $past(cfgHandleEn));
  // R9
  assert_err_bypass_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameValid && errFlag |=> resBypass);
  // R10
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !swClearErr |=> errFlag);
  // R10
  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    swClearErr |=> !errFlag);
endmodule

bind pn_replay_guard pn_replay_guard_sva u_sva (
  .clk(clk), .rstN(rstN), .cfgCheckEn(cfgCheckEn), .cfgHandleEn(cfgHandleEn),
  .frameValid(frameValid), .swClearErr(swClearErr), .resPass(resPass),
  .resFail(resFail), .resBypass(resBypass), .errFlag(errFlag)
);

// File: tb/pn_replay_guard_bench.sv
module pn_replay_guard_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgCheckEn = 1'b1, cfgEvenOnly = 1'b0, cfgOddOnly = 1'b0, cfgHandleEn = 1'b0;
  logic [1:0] cfgWidthSel = 2'd2;
  logic frameValid = 1'b0, swPreload = 1'b0, swClearErr = 1'b0;
  logic [127:0] framePn = '0, swPreloadPn = '0;
  logic resPass, resFail, resBypass, errFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [2:0] V_PASS = 3'b100, V_FAIL = 3'b010, V_BYP = 3'b001;

  typedef struct { logic [2:0] code; string tag; } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  pn_replay_guard u_pn_replay_guard (
    .clk(clk), .rstN(rstN), .cfgCheckEn(cfgCheckEn), .cfgWidthSel(cfgWidthSel),
    .cfgEvenOnly(cfgEvenOnly), .cfgOddOnly(cfgOddOnly), .cfgHandleEn(cfgHandleEn),
    .frameValid(frameValid), .framePn(framePn), .swPreload(swPreload),
    .swPreloadPn(swPreloadPn), .swClearErr(swClearErr), .resPass(resPass),
    .resFail(resFail), .resBypass(resBypass), .errFlag(errFlag)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: one frame, expected verdict into the scoreboard
  task automatic sendFrame(input logic [127:0] pn, input logic [2:0] code, input string tag,
                           input bit clr = 1'b0);
    expItem_t it;
    @(negedge clk);
    framePn = pn; frameValid = 1'b1; swClearErr = clr;
    it.code = code; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    frameValid = 1'b0; swClearErr = 1'b0;
  endtask

  task automatic preload(input logic [127:0] pn);
    @(negedge clk); swPreloadPn = pn; swPreload = 1'b1;
    @(negedge clk); swPreload = 1'b0;
  endtask

  task automatic clearErr();
    @(negedge clk); swClearErr = 1'b1;
    @(negedge clk); swClearErr = 1'b0;
  endtask

  // Monitor: compares verdicts shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      if ({resPass, resFail, resBypass} != 3'b000 || expQ.size() != 0) begin
        if (expQ.size() == 0)
          check("R1 unexpected verdict", {5'd0, resPass, resFail, resBypass}, 8'd0);
        else begin
          expItem_t it;
          it = expQ.pop_front();
          check(it.tag, {5'd0, resPass, resFail, resBypass}, {5'd0, it.code});
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R11 outputs after reset", {4'd0, resPass, resFail, resBypass, errFlag}, 8'd0);
        rstN = 1'b1;
        // R2 disabled check passes and captures nothing
        cfgCheckEn = 1'b0;
        sendFrame(128'd5, V_PASS, "R2 disabled pass");
        cfgCheckEn = 1'b1;
        sendFrame(128'd3, V_PASS, "R5 first frame captured");
        sendFrame(128'd3, V_FAIL, "R3 equal PN fails");
        sendFrame(128'd4, V_PASS, "R7 larger passes");
        sendFrame(128'd2, V_FAIL, "R7 smaller fails");
        sendFrame(128'd3, V_FAIL, "R7 reference kept after fail");
        // R3 width selection
        cfgWidthSel = 2'd0;
        sendFrame((128'd1 << 100) | 128'd2, V_FAIL, "R3 24-bit ignores high bits");
        sendFrame(128'h100_0005, V_PASS, "R3 24-bit low bits larger");
        sendFrame(128'd6, V_PASS, "R3 24-bit masked reference");
        cfgWidthSel = 2'd1;
        sendFrame((128'd1 << 48) | 128'd7, V_PASS, "R3 48-bit masked");
        cfgWidthSel = 2'd2;
        sendFrame(128'd8, V_FAIL, "R3 128-bit sees full reference");
        sendFrame(128'd1 << 127, V_PASS, "R3 128-bit top bit");
        // R4 parity rules
        preload(128'd10);
        cfgEvenOnly = 1'b1;
        sendFrame(128'd11, V_FAIL, "R4 even-only rejects odd");
        sendFrame(128'd12, V_PASS, "R4 even-only accepts even");
        cfgEvenOnly = 1'b0; cfgOddOnly = 1'b1;
        sendFrame(128'd14, V_FAIL, "R4 odd-only rejects even");
        sendFrame(128'd13, V_PASS, "R4 odd-only accepts odd");
        cfgOddOnly = 1'b0;
        // R6 preload
        preload(128'd1000);
        sendFrame(128'd500, V_FAIL, "R6 compared against preload");
        @(negedge clk);
        check("R8 no error without handling", {7'd0, errFlag}, 8'd0);
        cfgHandleEn = 1'b1;
        sendFrame(128'd5, V_FAIL, "R8 fail with handling");
        check("R8 error flag set", {7'd0, errFlag}, 8'd1);
        cfgHandleEn = 1'b0;
        sendFrame(128'd2000, V_BYP, "R9 bypass while error");
        cfgCheckEn = 1'b0;
        sendFrame(128'd1, V_BYP, "R9 bypass overrides disable");
        cfgCheckEn = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 flag sticky", {7'd0, errFlag}, 8'd1);
        clearErr();
        check("R10 cleared", {7'd0, errFlag}, 8'd0);
        sendFrame(128'd1001, V_PASS, "R9 reference untouched by bypass");
        cfgHandleEn = 1'b1;
        sendFrame(128'd3, V_FAIL, "R10 fail with clear", 1'b1);
        check("R10 clear beats set", {7'd0, errFlag}, 8'd0);
        cfgHandleEn = 1'b0;
        cfgWidthSel = 2'd3;
        sendFrame(128'd1 << 100, V_PASS, "R3 code 3 acts as 128-bit");
        cfgWidthSel = 2'd2;
        repeat (4) @(negedge clk);
        check("R1 scoreboard drained", 8'(expQ.size()), 8'd0);
      end
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule